// File: doc/BRIEF.md
# Parity-Protected Vectored Interrupt Manager

This block gathers up to `NUM_CH` interrupt request lines and steers each one to either the normal (IRQ) or the fast (FIQ) interrupt class. Within each class the lowest-numbered pending channel wins. The block reports the winner as an index, and it keeps a vector register per class that holds the handler address of that winner. Handler addresses sit in an internal vector RAM, and each entry carries an even-parity bit. The entry for channel `c` is in slot `c+1`. Slot 0 is a reserved phantom entry that dispatch never fetches.

When a dispatch fetch finds a parity mismatch, the block does four things:
- it loads the vector register with a programmable fallback address,
- it sets a sticky parity flag,
- it records the byte address of the failing entry,
- it pulses a correctable-error output toward an external error collector.

The presented vector is deliberately latched. Clearing the flag leaves the fallback address in place. Only a newly eligible request reloads it, and a mask clear followed by a mask set counts as newly eligible. A test mode lets software overwrite parity bits directly, so that errors can be injected.

Software reaches all registers through a simple single-cycle read/write bus. Read data appears on the cycle after the read strobe.

Top module: `vim_top`

## Requirements
- R1: Within each class the lowest-numbered pending unmasked channel wins. Its index is reported as channel+1, and 0 means nothing is pending. The steering register at 0x060+4*b (bit i of bank b is channel 32b+i) selects FIQ when the bit is 1 and IRQ when it is 0. The index is valid combinationally and can also be read at 0x010 (IRQ) and 0x014 (FIQ).
- R2: Each 32-channel mask bank b has a write-1-to-set register at 0x020+4*b and a write-1-to-clear register at 0x040+4*b. Reading either register returns the current mask. Channel 0 cannot be masked, so its bit always reads 1.
- R3: At the first clock edge where a channel becomes eligible (requested, unmasked, steered to the class), the vector register of that class loads from vector RAM slot winner+1. The vector RAM is at byte address 0x400+4*slot, channel 0 uses slot 1, and slot 0 is never fetched.
- R4: A fetch that finds a parity mismatch has these effects:
  - the vector register loads the fallback register (0x000) instead of the stored word;
  - the parity flag (0x008 bit 0) sets;
  - the error address register (0x00C) captures 0x400+4*slot, so bits [8:2] give the slot;
  - `par_err_o` is high for one cycle.
  If several errors occur in one cycle, the error address is taken first from an FIQ fetch, then from an IRQ fetch, then from a bus read.
- R5: Writing 1 to bit 0 of 0x008 clears the parity flag, and writing 0 has no effect. A new error in the same cycle as the clear wins.
- R6: Clearing the flag does not alter either vector register. A vector register changes only at a new eligibility edge in its class, and a mask clear and set counts as one.
- R7: A normal vector RAM write stores the word together with an even-parity bit equal to the XOR of its 32 bits. When test mode (0x004 bit 0) is 1, a write stores only `wdata[0]` as the parity bit and leaves the word unchanged.
- R8: A bus read of a vector RAM entry returns the stored word on the next cycle. If its parity is bad, the read sets the flag and error address and pulses `par_err_o`, but it leaves both vector registers unchanged.
- R9: After reset, the following all read 0: the indexes, the vectors, the flag, `par_err_o` and the fallback address. Mask bank 0 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_CH | Request lines, one per channel |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | An IRQ-class channel is pending |
| fiq_o | output | 1 | An FIQ-class channel is pending |
| irq_vec_o | output | 32 | Latched IRQ handler address |
| fiq_vec_o | output | 32 | Latched FIQ handler address |
| irq_index_o | output | $clog2(NUM_CH+1) | IRQ winner channel+1, 0 if none |
| fiq_index_o | output | $clog2(NUM_CH+1) | FIQ winner channel+1, 0 if none |
| par_err_o | output | 1 | One-cycle correctable parity error pulse |

## Verification
On every cycle, the assertions check the following:
- the two class indexes never exceed the channel count and never name the same channel;
- an unmaskable channel 0 steered to IRQ always wins;
- an error pulse never appears without the sticky flag;
- neither vector register changes unless a new-eligibility load happened at that edge.

Only the directed scenarios can show the rest:
- the value-level effects, which are the fetched addresses, the fallback substitution, the recorded error address, and write-0 versus write-1 on the flag;
- the repair sequence, in which the fallback address survives flag clearing and is replaced only after the mask is toggled;
- that a parity-bad bus read leaves the vectors alone.

// File: rtl/vim_pkg.sv
package vim_pkg;

    localparam logic [11:0] A_FALLBACK = 12'h000;
    localparam logic [11:0] A_PCTL     = 12'h004;
    localparam logic [11:0] A_PFLAG    = 12'h008;
    localparam logic [11:0] A_ERRADDR  = 12'h00C;
    localparam logic [11:0] A_IRQIDX   = 12'h010;
    localparam logic [11:0] A_FIQIDX   = 12'h014;
    localparam logic [11:0] A_MSET     = 12'h020;
    localparam logic [11:0] A_MCLR     = 12'h040;
    localparam logic [11:0] A_FSEL     = 12'h060;
    localparam logic [11:0] A_VRAM     = 12'h400;

    // One vector RAM entry: handler word plus its even-parity bit
    typedef struct packed {
        logic [31:0] data;
        logic        par;
    } vent_t;

endpackage

// File: rtl/vim_prio.sv
// Lowest-index-wins finder; reports winner+1, or 0 when nothing is pending.
module vim_prio #(
    parameter int N  = 96,
    parameter int IW = 7
) (
    input  logic [N-1:0]  pend_i,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IW'(i + 1);
        end
    end
endmodule

// File: rtl/vim_vecram.sv
// Vector storage with parity bit per slot, one write port and three checked read ports.
module vim_vecram
    import vim_pkg::*;
#(
    parameter int SLOTS = 97,
    parameter int SW    = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [SW-1:0]        wslot_i,
    input  logic [31:0]          wdata_i,
    input  logic                 tmode_i,
    input  logic [2:0][SW-1:0]   rslot_i,
    output logic [2:0][31:0]     rdata_o,
    output logic [2:0]           bad_o
);
    vent_t mem_q [SLOTS];
    vent_t mem_d [SLOTS];

    always_comb begin
        mem_d = mem_q;
        if (we_i && (32'(wslot_i) < SLOTS)) begin
            if (tmode_i) begin
                mem_d[wslot_i].par = wdata_i[0];
            end else begin
                mem_d[wslot_i].data = wdata_i;
                mem_d[wslot_i].par  = ^wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar p = 0; p < 3; p++) begin : g_rport
        logic  hit;
        vent_t ent;
        assign hit        = 32'(rslot_i[p]) < SLOTS;
        assign ent        = hit ? mem_q[rslot_i[p]] : '0;
        assign rdata_o[p] = ent.data;
        assign bad_o[p]   = hit && ((^ent.data) != ent.par);
    end
endmodule

// File: rtl/vim_top.sv
module vim_top
    import vim_pkg::*;
#(
    parameter int NUM_CH = 96,
    localparam int IW    = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [11:0]       bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [31:0]       irq_vec_o,
    output logic [31:0]       fiq_vec_o,
    output logic [IW-1:0]     irq_index_o,
    output logic [IW-1:0]     fiq_index_o,
    output logic              par_err_o
);
    localparam int NB    = (NUM_CH + 31) / 32;
    localparam int MW    = NB * 32;
    localparam int SLOTS = NUM_CH + 1;

    typedef struct packed {
        logic [31:0]       fallback;
        logic              tmode;
        logic              flag;
        logic [11:0]       erraddr;
        logic [MW-1:0]     mask;
        logic [MW-1:0]     fsel;
        logic [NUM_CH-1:0] irq_el;
        logic [NUM_CH-1:0] fiq_el;
        logic [31:0]       irq_vec;
        logic [31:0]       fiq_vec;
        logic              err;
        logic [31:0]       rdata;
    } state_t;

    state_t s_q, s_d;

    logic [NUM_CH-1:0]   el_irq, el_fiq;
    logic [IW-1:0]       irq_idx, fiq_idx;
    logic                irq_load, fiq_load;
    logic                is_vram, ram_we, ram_rd;
    logic [IW-1:0]       bslot;
    logic [2:0][IW-1:0]  rslot;
    logic [2:0][31:0]    rdat;
    logic [2:0]          rbad;
    logic [31:0]         rd_mux;

    function automatic logic [11:0] slot_addr(input logic [IW-1:0] s);
        return A_VRAM + 12'({s, 2'b00});
    endfunction

    assign el_irq   = req_i & s_q.mask[NUM_CH-1:0] & ~s_q.fsel[NUM_CH-1:0];
    assign el_fiq   = req_i & s_q.mask[NUM_CH-1:0] &  s_q.fsel[NUM_CH-1:0];
    assign irq_load = |(el_irq & ~s_q.irq_el);
    assign fiq_load = |(el_fiq & ~s_q.fiq_el);

    vim_prio #(.N(NUM_CH), .IW(IW)) u_prio_irq (.pend_i(el_irq), .idx_o(irq_idx));
    vim_prio #(.N(NUM_CH), .IW(IW)) u_prio_fiq (.pend_i(el_fiq), .idx_o(fiq_idx));

    assign is_vram = (bus_addr_i[11:10] == 2'b01) && (bus_addr_i[1:0] == 2'b00)
                     && (32'(bus_addr_i[9:2]) <= NUM_CH);
    assign bslot   = IW'(bus_addr_i[9:2]);
    assign ram_we  = bus_wr_i && is_vram;
    assign ram_rd  = bus_rd_i && is_vram;
    assign rslot   = {bslot, fiq_idx, irq_idx};

    vim_vecram #(.SLOTS(SLOTS), .SW(IW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ram_we),
        .wslot_i (bslot),
        .wdata_i (bus_wdata_i),
        .tmode_i (s_q.tmode),
        .rslot_i (rslot),
        .rdata_o (rdat),
        .bad_o   (rbad)
    );

    // Register read multiplexer
    always_comb begin
        rd_mux = '0;
        if (is_vram) rd_mux = rdat[2];
        case (bus_addr_i)
            A_FALLBACK: rd_mux = s_q.fallback;
            A_PCTL:     rd_mux = 32'(s_q.tmode);
            A_PFLAG:    rd_mux = 32'(s_q.flag);
            A_ERRADDR:  rd_mux = 32'(s_q.erraddr);
            A_IRQIDX:   rd_mux = 32'(irq_idx);
            A_FIQIDX:   rd_mux = 32'(fiq_idx);
            default: ;
        endcase
        for (int b = 0; b < NB; b++) begin
            if (bus_addr_i == A_MSET + 12'(4 * b) || bus_addr_i == A_MCLR + 12'(4 * b))
                rd_mux = s_q.mask[b*32 +: 32];
            if (bus_addr_i == A_FSEL + 12'(4 * b))
                rd_mux = s_q.fsel[b*32 +: 32];
        end
    end

    // Next-state computation
    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (bus_wr_i) begin
            if (bus_addr_i == A_FALLBACK) s_d.fallback = bus_wdata_i;
            if (bus_addr_i == A_PCTL)     s_d.tmode    = bus_wdata_i[0];
            if (bus_addr_i == A_PFLAG && bus_wdata_i[0]) s_d.flag = 1'b0;
            for (int b = 0; b < NB; b++) begin
                if (bus_addr_i == A_MSET + 12'(4 * b))
                    s_d.mask[b*32 +: 32] = s_q.mask[b*32 +: 32] | bus_wdata_i;
                if (bus_addr_i == A_MCLR + 12'(4 * b))
                    s_d.mask[b*32 +: 32] = s_q.mask[b*32 +: 32] & ~bus_wdata_i;
                if (bus_addr_i == A_FSEL + 12'(4 * b))
                    s_d.fsel[b*32 +: 32] = bus_wdata_i;
            end
        end
        s_d.mask[0] = 1'b1;

        s_d.irq_el = el_irq;
        s_d.fiq_el = el_fiq;
        if (irq_load) s_d.irq_vec = rbad[0] ? s_q.fallback : rdat[0];
        if (fiq_load) s_d.fiq_vec = rbad[1] ? s_q.fallback : rdat[1];

        // Error capture, lowest priority first so later sources override
        if (ram_rd && rbad[2]) begin
            s_d.flag = 1'b1; s_d.err = 1'b1; s_d.erraddr = slot_addr(bslot);
        end
        if (irq_load && rbad[0]) begin
            s_d.flag = 1'b1; s_d.err = 1'b1; s_d.erraddr = slot_addr(irq_idx);
        end
        if (fiq_load && rbad[1]) begin
            s_d.flag = 1'b1; s_d.err = 1'b1; s_d.erraddr = slot_addr(fiq_idx);
        end

        if (bus_rd_i) s_d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.mask[0] <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata_o = s_q.rdata;
    assign irq_index_o = irq_idx;
    assign fiq_index_o = fiq_idx;
    assign irq_o       = irq_idx != '0;
    assign fiq_o       = fiq_idx != '0;
    assign irq_vec_o   = s_q.irq_vec;
    assign fiq_vec_o   = s_q.fiq_vec;
    assign par_err_o   = s_q.err;
endmodule

// File: rtl/vim_checker.sv
module vim_checker #(
    parameter int NUM_CH = 96,
    localparam int IW    = $clog2(NUM_CH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] req_i,
    input logic [IW-1:0]     irq_index_o,
    input logic [IW-1:0]     fiq_index_o,
    input logic [31:0]       irq_vec_o,
    input logic [31:0]       fiq_vec_o,
    input logic              par_err_o,
    input logic              par_flag,
    input logic              fsel0,
    input logic              irq_load,
    input logic              fiq_load
);
    assert_index_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(irq_index_o) <= NUM_CH) && (32'(fiq_index_o) <= NUM_CH));

    assert_classes_distinct_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_index_o != '0 && fiq_index_o != '0) |-> irq_index_o != fiq_index_o);

    assert_ch0_unmaskable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i[0] && !fsel0) |-> irq_index_o == IW'(1));

    assert_pulse_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_o |-> par_flag);

    assert_irq_vec_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec_o != $past(irq_vec_o)) |-> $past(irq_load));

    assert_fiq_vec_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_vec_o != $past(fiq_vec_o)) |-> $past(fiq_load));
endmodule

bind vim_top vim_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .irq_index_o (irq_index_o),
    .fiq_index_o (fiq_index_o),
    .irq_vec_o   (irq_vec_o),
    .fiq_vec_o   (fiq_vec_o),
    .par_err_o   (par_err_o),
    .par_flag    (s_q.flag),
    .fsel0       (s_q.fsel[0]),
    .irq_load    (irq_load),
    .fiq_load    (fiq_load)
);

// File: tb/tb_vim_top.sv
module tb_vim_top;
    localparam int NUM_CH = 96;
    localparam int IW     = $clog2(NUM_CH + 1);
    localparam logic [31:0] FB = 32'hDEAD_BEE0;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] req = '0;
    logic              wr = 1'b0, rd = 1'b0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq, fiq, perr;
    logic [31:0]       ivec, fvec;
    logic [IW-1:0]     iidx, fidx;

    int ntot = 0, nfail = 0;

    always #10 clk = ~clk;

    vim_top #(.NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq),
        .irq_vec_o(ivec), .fiq_vec_o(fvec),
        .irq_index_o(iidx), .fiq_index_o(fidx), .par_err_o(perr)
    );

    function automatic logic [31:0] vec_of(input int slot);
        return 32'h1000_0000 | (32'(slot) << 4);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", ntot - nfail, ntot);
        $finish;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R9 irq index", 32'(iidx), 0);
        chk("R9 fiq index", 32'(fidx), 0);
        chk("R9 irq vec", ivec, 0);
        chk("R9 fiq vec", fvec, 0);
        chk("R9 par_err", 32'(perr), 0);
        bread(12'h008, d); chk("R9 flag", d, 0);
        bread(12'h000, d); chk("R9 fallback", d, 0);
        bread(12'h020, d); chk("R9 R2 mask bank0", d, 1);
    endtask

    task automatic t_priority;
        bwrite(12'h020, 32'h1 << 5);
        bwrite(12'h024, 32'h1 << 8);
        bwrite(12'h028, 32'h1 << 6);
        bwrite(12'h064, 32'h1 << 8);
        @(negedge clk); req[70] = 1'b1;
        @(negedge clk);
        chk("R1 irq idx ch70", 32'(iidx), 71);
        chk("R3 irq vec ch70", ivec, vec_of(71));
        chk("R1 fiq idle", 32'(fidx), 0);
        req[5] = 1'b1;
        @(negedge clk);
        chk("R1 lowest wins", 32'(iidx), 6);
        chk("R3 irq vec ch5", ivec, vec_of(6));
        req[40] = 1'b1;
        @(negedge clk);
        chk("R1 fiq steer", 32'(fidx), 41);
        chk("R3 fiq vec ch40", fvec, vec_of(41));
        chk("R1 irq unaffected", 32'(iidx), 6);
        req[40] = 1'b0; req[5] = 1'b0;
        @(negedge clk);
        chk("R1 fallback to ch70", 32'(iidx), 71);
        chk("R6 vec held w/o new req", ivec, vec_of(6));
        req = '0;
        cyc(1);
    endtask

    task automatic t_ch0;
        @(negedge clk); req[0] = 1'b1;
        @(negedge clk);
        chk("R2 ch0 idx", 32'(iidx), 1);
        chk("R3 ch0 uses slot1", ivec, vec_of(1));
        req[0] = 1'b0;
        cyc(1);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        bwrite(12'h040, 32'hFFFF_FFFF);
        bread(12'h020, d); chk("R2 ch0 not maskable (set reg)", d, 1);
        bread(12'h040, d); chk("R2 clr reg reads mask", d, 1);
        @(negedge clk); req[5] = 1'b1;
        @(negedge clk);
        chk("R2 masked ch5 ignored", 32'(iidx), 0);
        chk("R6 vec unchanged by masked req", ivec, vec_of(1));
        bwrite(12'h020, 32'h1 << 5);
        chk("R2 unmask index", 32'(iidx), 6);
        @(negedge clk);
        chk("R3 reload after unmask", ivec, vec_of(6));
        req = '0;
        cyc(1);
    endtask

    task automatic t_parity;
        logic [31:0] d;
        bwrite(12'h000, FB);
        bwrite(12'h020, 32'h1 << 30);
        bwrite(12'h004, 32'h1);
        bwrite(12'h400 + 12'(31 * 4), 32'(~(^vec_of(31))));
        bwrite(12'h004, 32'h0);
        @(negedge clk); req[30] = 1'b1;
        @(negedge clk);
        chk("R4 fallback on bad parity", ivec, FB);
        chk("R4 pulse", 32'(perr), 1);
        chk("R4 idx", 32'(iidx), 31);
        @(negedge clk);
        chk("R4 pulse one cycle", 32'(perr), 0);
        bread(12'h008, d); chk("R4 flag set", d, 1);
        bread(12'h00C, d); chk("R4 err addr", d, 32'h47C);
        chk("R4 slot bits", 32'(d[8:2]), 31);
        bwrite(12'h008, 32'h0);
        bread(12'h008, d); chk("R5 write0 no effect", d, 1);
        bwrite(12'h008, 32'h1);
        bread(12'h008, d); chk("R5 write1 clears", d, 0);
        chk("R6 vec held after clear", ivec, FB);
        bwrite(12'h400 + 12'(31 * 4), vec_of(31));
        bread(12'h400 + 12'(31 * 4), d);
        chk("R7 normal write even parity", 32'(perr), 0);
        chk("R6 vec held after repair", ivec, FB);
        bwrite(12'h040, 32'h1 << 30);
        bwrite(12'h020, 32'h1 << 30);
        @(negedge clk);
        chk("R6 reload after mask toggle", ivec, vec_of(31));
        req = '0;
        cyc(1);
    endtask

    task automatic t_busread;
        logic [31:0] d;
        bwrite(12'h004, 32'h1);
        bwrite(12'h400 + 12'(52 * 4), 32'(~(^vec_of(52))));
        bwrite(12'h004, 32'h0);
        bread(12'h400 + 12'(52 * 4), d);
        chk("R7 test write keeps data", d, vec_of(52));
        chk("R8 bus read pulse", 32'(perr), 1);
        chk("R8 irq vec untouched", ivec, vec_of(31));
        chk("R8 fiq vec untouched", fvec, vec_of(41));
        bread(12'h008, d); chk("R8 flag set", d, 1);
        bread(12'h00C, d); chk("R8 err addr", d, 32'h4D0);
        bwrite(12'h008, 32'h1);
        // FIQ fetch of the same bad entry (ch51, bank1 bit19)
        bwrite(12'h064, 32'h1 << 19);
        bwrite(12'h024, 32'h1 << 19);
        @(negedge clk); req[51] = 1'b1;
        @(negedge clk);
        chk("R4 fiq fallback", fvec, FB);
        chk("R4 fiq pulse", 32'(perr), 1);
        bread(12'h00C, d); chk("R4 fiq err addr", d, 32'h4D0);
        req = '0;
    endtask

    initial begin
        #(20 * 100000);
        ntot++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        for (int s = 0; s <= NUM_CH; s++) bwrite(12'h400 + 12'(s * 4), vec_of(s));
        t_priority();
        t_ch0();
        t_mask();
        t_parity();
        t_busread();
        cyc(2);
        summary();
    end
endmodule